// File: doc/BRIEF.md
# Command-Byte Register Access Decoder

This block is the register-file front end of a small optical sensor peripheral. It sits behind a serial target interface that has already been reduced to bytes. That interface delivers a write strobe with a data byte, a read request, and one-cycle start and stop framing pulses. The first byte written after any framing pulse is taken as a command. The command loads a register pointer and an access mode, or it fires a special-function strobe. Later bytes then read or write the register at the pointer.

The register map holds byte-wide control fields and two 16-bit thresholds, all of which software can write. It also holds a fixed identity code, a status byte supplied from outside, and several 16-bit measurement channels. Every 16-bit value is stored low byte first, so an auto-incrementing two-byte access moves a whole word. When the low byte of a measurement channel is read, the block captures that channel's high byte. The next high-byte read returns the captured value, so the word stays coherent while the measurement logic keeps updating.

Top module: `cmdreg_front`

## Requirements
- R1: Only the first byte after a start or stop pulse (or a byte arriving in the same cycle as one) can be a command. The block accepts it only when bit 7 is 1. A first byte with bit 7 at 0 changes nothing, and the block keeps waiting for a command.
- R2: A command whose bits 6:5 are 00 loads the pointer from bits 4:0 and selects fixed access. Every later read or write byte then uses that same address.
- R3: A command whose bits 6:5 are 01 loads the pointer and selects stepping access. The pointer advances by one after each read or write byte, and 0x1F steps to 0x00.
- R4: Command 0xE6 (bits 6:5 = 11, code 0x06) raises `irq_clear` for exactly the one cycle that follows the byte. Pointer and mode are left alone. Other codes with bits 6:5 = 11, and every command with bits 6:5 = 10, change neither the pointer nor the mode, and raise no pulse. A data byte of value 0xE6 raises no pulse.
- R5: These addresses can be written and read back as full bytes: enable 0x00 (reset 0x00), integration time 0x01 (reset 0xFF), wait time 0x03 (reset 0xFF), low threshold 0x04 (low byte) and 0x05 (high byte), high threshold 0x06 (low byte) and 0x07 (high byte), persistence 0x0C, configuration 0x0D and gain 0x0F. All not listed with a reset value reset to 0x00.
- R6: Address 0x12 reads the `ID_CODE` parameter (default 0x44), and writes to it are discarded.
- R7: Address 0x13 reads `status_in`. Channel k (k = 0..3) has its low byte at 0x14+2k, which reads `chan_data[16k+7:16k]`, and its high byte at 0x15+2k.
- R8: Reading the low byte of channel k captures `chan_data[16k+15:16k+8]` in that same cycle. A read of address 0x15+2k returns the last captured value for channel k, even if `chan_data` has changed since, and returns 0x00 if nothing has been captured since reset.
- R9: Writes to 0x10–0x1F are discarded. Reads of 0x02, 0x08–0x0B, 0x0E, 0x10, 0x11 and 0x1C–0x1F return 0x00.
- R10: `rd_data` takes the value read in the cycle after a read request that has no write alongside it. At all other times it holds its value. A write in the same cycle takes priority and the read is dropped.
- R11: The `cfg_*` outputs show a written value in the cycle after the write byte.
- R12: The pointer and mode persist across start and stop pulses, so a write of a command followed by a repeated start and reads addresses the commanded register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Start or repeated-start framing pulse |
| xfer_stop | input | 1 | Stop framing pulse |
| wr_valid | input | 1 | A written byte is present on wr_data |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Request for one read byte |
| rd_data | output | 8 | Registered read byte |
| status_in | input | 8 | Status byte from the measurement logic |
| chan_data | input | NUM_CHAN*16 | Measurement words, channel k in bits 16k+15:16k |
| irq_clear | output | 1 | One-cycle pulse from the interrupt-clear command |
| cfg_enable | output | 8 | Enable register |
| cfg_itime | output | 8 | Integration-time register |
| cfg_wtime | output | 8 | Wait-time register |
| cfg_thr_low | output | 16 | Low threshold |
| cfg_thr_high | output | 16 | High threshold |
| cfg_persist | output | 8 | Persistence register |
| cfg_config | output | 8 | Configuration register |
| cfg_gain | output | 8 | Gain register |

## Verification
A pointer that has drifted shows up at the very next read byte as a value from the wrong register, and at the next write as a change on the wrong `cfg_*` output one cycle later. A stuck "awaiting command" flag makes data bytes act as commands, or makes commands land in registers. Either fault appears within one transaction. A stale or wrongly captured channel high byte appears only on the high-byte read that follows, so the bench changes `chan_data` between the two halves of a word read to expose it.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

    localparam int ADDR_W = 5;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] A_ENABLE = 5'h00;
    localparam logic [ADDR_W-1:0] A_ITIME  = 5'h01;
    localparam logic [ADDR_W-1:0] A_WTIME  = 5'h03;
    localparam logic [ADDR_W-1:0] A_TLO_L  = 5'h04;
    localparam logic [ADDR_W-1:0] A_TLO_H  = 5'h05;
    localparam logic [ADDR_W-1:0] A_THI_L  = 5'h06;
    localparam logic [ADDR_W-1:0] A_THI_H  = 5'h07;
    localparam logic [ADDR_W-1:0] A_PERS   = 5'h0C;
    localparam logic [ADDR_W-1:0] A_CONFIG = 5'h0D;
    localparam logic [ADDR_W-1:0] A_GAIN   = 5'h0F;
    localparam logic [ADDR_W-1:0] A_ID     = 5'h12;
    localparam logic [ADDR_W-1:0] A_STATUS = 5'h13;
    localparam int                CHAN_BASE = 'h14;

    localparam logic [1:0] T_FIXED = 2'b00;
    localparam logic [1:0] T_STEP  = 2'b01;
    localparam logic [1:0] T_SPEC  = 2'b11;
    localparam logic [ADDR_W-1:0] SF_IRQ_CLR = 5'h06;

    typedef struct packed {
        logic              is_cmd;
        logic              load_ptr;
        logic              step;
        logic              clr_irq;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic [BYTE_W-1:0] enable;
        logic [BYTE_W-1:0] itime;
        logic [BYTE_W-1:0] wtime;
        logic [15:0]       thr_lo;
        logic [15:0]       thr_hi;
        logic [BYTE_W-1:0] pers;
        logic [BYTE_W-1:0] config_r;
        logic [BYTE_W-1:0] gain;
    } cfg_t;

    localparam cfg_t CFG_RST = '{
        enable: 8'h00, itime: 8'hFF, wtime: 8'hFF, thr_lo: 16'h0000,
        thr_hi: 16'h0000, pers: 8'h00, config_r: 8'h00, gain: 8'h00
    };

    function automatic cfg_t cfg_write(cfg_t c, logic [ADDR_W-1:0] a, logic [BYTE_W-1:0] b);
        cfg_t r = c;
        case (a)
            A_ENABLE: r.enable       = b;
            A_ITIME:  r.itime        = b;
            A_WTIME:  r.wtime        = b;
            A_TLO_L:  r.thr_lo[7:0]  = b;
            A_TLO_H:  r.thr_lo[15:8] = b;
            A_THI_L:  r.thr_hi[7:0]  = b;
            A_THI_H:  r.thr_hi[15:8] = b;
            A_PERS:   r.pers         = b;
            A_CONFIG: r.config_r     = b;
            A_GAIN:   r.gain         = b;
            default:  r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cmdreg_cmd_decode.sv
module cmdreg_cmd_decode
    import cmdreg_pkg::*;
(
    input  logic [BYTE_W-1:0] byte_i,
    output cmd_t              cmd_o
);
    logic [1:0] kind;

    always_comb begin
        kind           = byte_i[6:5];
        cmd_o.is_cmd   = byte_i[7];
        cmd_o.addr     = byte_i[ADDR_W-1:0];
        cmd_o.step     = (kind == T_STEP);
        cmd_o.load_ptr = byte_i[7] && ((kind == T_FIXED) || (kind == T_STEP));
        cmd_o.clr_irq  = byte_i[7] && (kind == T_SPEC) && (byte_i[ADDR_W-1:0] == SF_IRQ_CLR);
    end
endmodule

// File: rtl/cmdreg_rd_mux.sv
module cmdreg_rd_mux
    import cmdreg_pkg::*;
#(
    parameter logic [7:0] ID_CODE  = 8'h44,
    parameter int         NUM_CHAN = 4
) (
    input  logic [ADDR_W-1:0]               addr_i,
    input  cfg_t                            cfg_i,
    input  logic [BYTE_W-1:0]               status_i,
    input  logic [NUM_CHAN*16-1:0]          chan_i,
    input  logic [NUM_CHAN-1:0][BYTE_W-1:0] shadow_i,
    output logic [BYTE_W-1:0]               byte_o,
    output logic [NUM_CHAN-1:0]             lo_hit_o
);
    logic [NUM_CHAN-1:0]             hi_hit;
    logic [NUM_CHAN-1:0][BYTE_W-1:0] chan_val;
    logic [BYTE_W-1:0]               base_val;

    for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
        assign lo_hit_o[g] = (addr_i == ADDR_W'(CHAN_BASE + 2*g));
        assign hi_hit[g]   = (addr_i == ADDR_W'(CHAN_BASE + 2*g + 1));
        assign chan_val[g] = lo_hit_o[g] ? chan_i[16*g +: 8] :
                             hi_hit[g]   ? shadow_i[g]       : 8'h00;
    end

    always_comb begin
        case (addr_i)
            A_ENABLE: base_val = cfg_i.enable;
            A_ITIME:  base_val = cfg_i.itime;
            A_WTIME:  base_val = cfg_i.wtime;
            A_TLO_L:  base_val = cfg_i.thr_lo[7:0];
            A_TLO_H:  base_val = cfg_i.thr_lo[15:8];
            A_THI_L:  base_val = cfg_i.thr_hi[7:0];
            A_THI_H:  base_val = cfg_i.thr_hi[15:8];
            A_PERS:   base_val = cfg_i.pers;
            A_CONFIG: base_val = cfg_i.config_r;
            A_GAIN:   base_val = cfg_i.gain;
            A_ID:     base_val = ID_CODE;
            A_STATUS: base_val = status_i;
            default:  base_val = 8'h00;
        endcase
        byte_o = base_val;
        for (int i = 0; i < NUM_CHAN; i++) begin
            byte_o = byte_o | chan_val[i];
        end
    end
endmodule

// File: rtl/cmdreg_front.sv
module cmdreg_front
    import cmdreg_pkg::*;
#(
    parameter logic [7:0] ID_CODE  = 8'h44,
    parameter int         NUM_CHAN = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     xfer_start,
    input  logic                     xfer_stop,
    input  logic                     wr_valid,
    input  logic [7:0]               wr_data,
    input  logic                     rd_req,
    output logic [7:0]               rd_data,
    input  logic [7:0]               status_in,
    input  logic [NUM_CHAN*16-1:0]   chan_data,
    output logic                     irq_clear,
    output logic [7:0]               cfg_enable,
    output logic [7:0]               cfg_itime,
    output logic [7:0]               cfg_wtime,
    output logic [15:0]              cfg_thr_low,
    output logic [15:0]              cfg_thr_high,
    output logic [7:0]               cfg_persist,
    output logic [7:0]               cfg_config,
    output logic [7:0]               cfg_gain
);
    typedef struct packed {
        cfg_t                            cfg;
        logic [ADDR_W-1:0]               ptr;
        logic                            step;
        logic                            await_cmd;
        logic [BYTE_W-1:0]               rd_byte;
        logic                            irq_clr;
        logic [NUM_CHAN-1:0][BYTE_W-1:0] shadow;
    } state_t;

    state_t st_d, st_q;
    cmd_t   cmd;
    logic   first_byte;
    logic [BYTE_W-1:0]   mux_byte;
    logic [NUM_CHAN-1:0] lo_hit;

    // signals seen by the bound checker
    logic [ADDR_W-1:0] ptr_q;
    logic              step_q;
    logic              await_q;
    assign ptr_q   = st_q.ptr;
    assign step_q  = st_q.step;
    assign await_q = st_q.await_cmd;

    cmdreg_cmd_decode u_dec (
        .byte_i (wr_data),
        .cmd_o  (cmd)
    );

    cmdreg_rd_mux #(.ID_CODE(ID_CODE), .NUM_CHAN(NUM_CHAN)) u_mux (
        .addr_i   (st_q.ptr),
        .cfg_i    (st_q.cfg),
        .status_i (status_in),
        .chan_i   (chan_data),
        .shadow_i (st_q.shadow),
        .byte_o   (mux_byte),
        .lo_hit_o (lo_hit)
    );

    always_comb begin
        st_d         = st_q;
        st_d.irq_clr = 1'b0;
        first_byte   = st_q.await_cmd | xfer_start | xfer_stop;
        if (xfer_start || xfer_stop) begin
            st_d.await_cmd = 1'b1;
        end
        if (wr_valid) begin
            if (first_byte) begin
                if (cmd.is_cmd) begin
                    st_d.await_cmd = 1'b0;
                    st_d.irq_clr   = cmd.clr_irq;
                    if (cmd.load_ptr) begin
                        st_d.ptr  = cmd.addr;
                        st_d.step = cmd.step;
                    end
                end
            end else begin
                st_d.cfg = cfg_write(st_q.cfg, st_q.ptr, wr_data);
                if (st_q.step) begin
                    st_d.ptr = st_q.ptr + 1'b1;
                end
            end
        end else if (rd_req) begin
            st_d.rd_byte = mux_byte;
            if (st_q.step) begin
                st_d.ptr = st_q.ptr + 1'b1;
            end
            for (int i = 0; i < NUM_CHAN; i++) begin
                if (lo_hit[i]) begin
                    st_d.shadow[i] = chan_data[16*i+8 +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cfg       <= CFG_RST;
            st_q.ptr       <= '0;
            st_q.step      <= 1'b0;
            st_q.await_cmd <= 1'b1;
            st_q.rd_byte   <= '0;
            st_q.irq_clr   <= 1'b0;
            st_q.shadow    <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data      = st_q.rd_byte;
    assign irq_clear    = st_q.irq_clr;
    assign cfg_enable   = st_q.cfg.enable;
    assign cfg_itime    = st_q.cfg.itime;
    assign cfg_wtime    = st_q.cfg.wtime;
    assign cfg_thr_low  = st_q.cfg.thr_lo;
    assign cfg_thr_high = st_q.cfg.thr_hi;
    assign cfg_persist  = st_q.cfg.pers;
    assign cfg_config   = st_q.cfg.config_r;
    assign cfg_gain     = st_q.cfg.gain;
endmodule

// File: rtl/cmdreg_front_chk.sv
module cmdreg_front_chk #(
    parameter logic [7:0] ID_CODE = 8'h44
) (
    input logic        clk,
    input logic        rst_n,
    input logic        xfer_start,
    input logic        xfer_stop,
    input logic        wr_valid,
    input logic [7:0]  wr_data,
    input logic        rd_req,
    input logic [7:0]  rd_data,
    input logic        irq_clear,
    input logic [4:0]  ptr,
    input logic        step,
    input logic        await_cmd,
    input logic [87:0] cfg_bits
);
    p_irq_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_clear |-> $past(wr_valid && wr_data == 8'hE6));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_req && !wr_valid) |-> $stable(rd_data));

    p_id_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req && !wr_valid && ptr == 5'h12) |-> rd_data == ID_CODE);

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req && !wr_valid && step) |-> ptr == $past(ptr) + 5'd1);

    p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_req && !wr_valid && !step) |-> ptr == $past(ptr));

    p_ro_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_valid && !(await_cmd || xfer_start || xfer_stop) && ptr >= 5'h10)
        |-> $stable(cfg_bits));
endmodule

bind cmdreg_front cmdreg_front_chk #(.ID_CODE(ID_CODE)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer_start (xfer_start),
    .xfer_stop  (xfer_stop),
    .wr_valid   (wr_valid),
    .wr_data    (wr_data),
    .rd_req     (rd_req),
    .rd_data    (rd_data),
    .irq_clear  (irq_clear),
    .ptr        (ptr_q),
    .step       (step_q),
    .await_cmd  (await_q),
    .cfg_bits   ({cfg_enable, cfg_itime, cfg_wtime, cfg_thr_low, cfg_thr_high,
                  cfg_persist, cfg_config, cfg_gain})
);

// File: tb/cmdreg_front_bench.sv
module cmdreg_front_bench;
    localparam logic [7:0] IDC = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_start = 1'b0, xfer_stop = 1'b0;
    logic        wr_valid = 1'b0, rd_req = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  status_in = 8'h00;
    logic [63:0] chan_data = 64'h0;
    logic [7:0]  rd_data;
    logic        irq_clear;
    logic [7:0]  cfg_enable, cfg_itime, cfg_wtime, cfg_persist, cfg_config, cfg_gain;
    logic [15:0] cfg_thr_low, cfg_thr_high;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model
    logic [7:0] mreg [32];
    logic [7:0] mshadow [4];
    logic [4:0] mptr;
    bit         mstep, mawait;

    always #4 clk = ~clk;

    cmdreg_front #(.ID_CODE(IDC), .NUM_CHAN(4)) u_cmdreg_front (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_stop(xfer_stop),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .status_in(status_in), .chan_data(chan_data), .irq_clear(irq_clear),
        .cfg_enable(cfg_enable), .cfg_itime(cfg_itime), .cfg_wtime(cfg_wtime),
        .cfg_thr_low(cfg_thr_low), .cfg_thr_high(cfg_thr_high),
        .cfg_persist(cfg_persist), .cfg_config(cfg_config), .cfg_gain(cfg_gain)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic bit is_wr(input logic [4:0] a);
        return a inside {5'h00, 5'h01, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07,
                         5'h0C, 5'h0D, 5'h0F};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [4:0] a);
        if (is_wr(a)) return mreg[a];
        if (a == 5'h12) return IDC;
        if (a == 5'h13) return status_in;
        if (a >= 5'h14 && a <= 5'h1B) begin
            if (a[0] == 1'b0) return chan_data[16*((a-5'h14)>>1) +: 8];
            return mshadow[(a-5'h14)>>1];
        end
        return 8'h00;
    endfunction

    task automatic frame(input bit is_start);
        @(negedge clk);
        if (is_start) xfer_start = 1'b1; else xfer_stop = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0; xfer_stop = 1'b0;
        mawait = 1;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        bit exp_irq;
        exp_irq = mawait && (b == 8'hE6);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
        chk("R4 irq_clear after byte", irq_clear, exp_irq);
        if (mawait) begin
            if (b[7]) begin
                mawait = 0;
                if (b[6:5] == 2'b00 || b[6:5] == 2'b01) begin
                    mptr = b[4:0]; mstep = (b[6:5] == 2'b01);
                end
            end
        end else begin
            if (is_wr(mptr)) mreg[mptr] = b;
            if (mstep) mptr = mptr + 5'd1;
        end
    endtask

    task automatic rd_byte(input string req);
        logic [7:0] e;
        logic [4:0] a;
        @(negedge clk);
        a = mptr;
        e = exp_rd(a);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk(req, rd_data, e);
        if (a >= 5'h14 && a <= 5'h1B && a[0] == 1'b0)
            mshadow[(a-5'h14)>>1] = chan_data[16*((a-5'h14)>>1)+8 +: 8];
        if (mstep) mptr = mptr + 5'd1;
    endtask

    task automatic chk_cfg();
        chk("R11 enable", cfg_enable, mreg[0]);
        chk("R11 itime", cfg_itime, mreg[1]);
        chk("R11 wtime", cfg_wtime, mreg[3]);
        chk("R11 thr_low", cfg_thr_low, {mreg[5], mreg[4]});
        chk("R11 thr_high", cfg_thr_high, {mreg[7], mreg[6]});
        chk("R11 persist", cfg_persist, mreg[12]);
        chk("R11 config", cfg_config, mreg[13]);
        chk("R11 gain", cfg_gain, mreg[15]);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] keep;
        int seed;
        for (int i = 0; i < 32; i++) mreg[i] = 8'h00;
        mreg[1] = 8'hFF; mreg[3] = 8'hFF;
        for (int i = 0; i < 4; i++) mshadow[i] = 8'h00;
        mptr = 0; mstep = 0; mawait = 1;
        seed = 20240611;
        void'($urandom(seed));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R10 reset rd_data", rd_data, 8'h00);
        chk("R4 reset irq_clear", irq_clear, 1'b0);
        chk("R5 reset itime", cfg_itime, 8'hFF);
        chk("R5 reset wtime", cfg_wtime, 8'hFF);
        chk("R5 reset enable", cfg_enable, 8'h00);

        // R1: first byte with bit 7 clear ignored, then a real command
        frame(1); wr_byte(8'h01); wr_byte(8'h81); wr_byte(8'h55); frame(0);
        chk("R1 ignored byte left enable", cfg_enable, 8'h00);
        chk("R1 command after ignored byte", cfg_itime, 8'h55);

        // R2: fixed access writes the same register repeatedly
        frame(1); wr_byte(8'h83); wr_byte(8'h11); wr_byte(8'h22); frame(0);
        chk("R2 repeated write wtime", cfg_wtime, 8'h22);
        chk("R2 neighbour untouched", cfg_thr_low, 16'h0000);
        frame(1); wr_byte(8'h83); frame(1); rd_byte("R2 read 1"); rd_byte("R2 read 2"); frame(0);

        // R5/R11: word writes through stepping access
        frame(1); wr_byte(8'hA4); wr_byte(8'h34); wr_byte(8'h12); wr_byte(8'h78); wr_byte(8'h56); frame(0);
        chk("R5 low threshold word", cfg_thr_low, 16'h1234);
        chk("R5 high threshold word", cfg_thr_high, 16'h5678);
        frame(1); wr_byte(8'hAC); wr_byte(8'h9A); wr_byte(8'hBC); wr_byte(8'hEE); wr_byte(8'hC7); frame(0);
        chk_cfg();

        // R6/R7/R9: identity, status, discarded writes, unmapped reads
        status_in = 8'h11;
        frame(1); wr_byte(8'hB2); frame(1); rd_byte("R6 id"); rd_byte("R7 status"); frame(0);
        frame(1); wr_byte(8'h92); wr_byte(8'h00); frame(0);
        frame(1); wr_byte(8'h92); frame(1); rd_byte("R6 id after write"); frame(0);
        frame(1); wr_byte(8'h93); wr_byte(8'h5A); frame(0);
        chk_cfg();
        frame(1); wr_byte(8'h82); frame(1); rd_byte("R9 unmapped 0x02"); frame(0);
        frame(1); wr_byte(8'h8E); frame(1); rd_byte("R9 unmapped 0x0E"); frame(0);
        frame(1); wr_byte(8'h9F); frame(1); rd_byte("R9 unmapped 0x1F"); frame(0);

        // R7/R8: channel reads with coherence across a data change
        chan_data = 64'h4455_6677_8899_AABB;
        frame(1); wr_byte(8'hB5); frame(1); rd_byte("R8 high before capture"); frame(0);
        frame(1); wr_byte(8'hB4); frame(1);
        rd_byte("R7 clear low");
        chan_data = 64'h0102_0304_0506_0708;
        rd_byte("R8 clear high coherent");
        rd_byte("R7 red low"); rd_byte("R8 red high");
        rd_byte("R7 green low"); rd_byte("R8 green high");
        rd_byte("R7 blue low"); rd_byte("R8 blue high");
        frame(0);

        // R3: wrap from 0x1F to 0x00
        frame(1); wr_byte(8'hBF); frame(1); rd_byte("R3 0x1F"); rd_byte("R3 wrapped to 0x00"); frame(0);

        // R4: special functions leave pointer and mode
        frame(1); wr_byte(8'h81); frame(0);
        frame(1); wr_byte(8'hE6); frame(1); rd_byte("R4 pointer kept after 0xE6"); frame(0);
        frame(1); wr_byte(8'hE5); wr_byte(8'h3C); frame(0);
        chk("R4 other special code writes old pointer", cfg_itime, 8'h3C);
        frame(1); wr_byte(8'hC3); wr_byte(8'h4D); frame(0);
        chk("R4 type 10 leaves pointer", cfg_itime, 8'h4D);
        frame(1); wr_byte(8'h80); wr_byte(8'hE6); frame(0);
        chk("R4 data 0xE6 written", cfg_enable, 8'hE6);

        // R10: rd_data holds without a read request, and while writing
        frame(1); wr_byte(8'h81); frame(1); rd_byte("R10 read"); keep = rd_data; frame(0);
        repeat (3) @(negedge clk);
        chk("R10 hold idle", rd_data, keep);
        frame(1); wr_byte(8'h80); wr_byte(8'h07); frame(0);
        chk("R10 hold across write", rd_data, keep);

        // R12: pointer survives stop and start
        frame(1); wr_byte(8'hA6); frame(0); frame(1); frame(1);
        rd_byte("R12 persisted pointer"); rd_byte("R12 persisted step"); frame(0);

        // random mixed traffic
        for (int t = 0; t < 400; t++) begin
            int r, n;
            logic [7:0] c;
            chan_data = {$urandom, $urandom};
            status_in = 8'($urandom);
            frame(1);
            r = $urandom % 10;
            if (r == 0) c = 8'hE6;
            else if (r == 1) c = 8'($urandom);
            else c = {1'b1, (($urandom % 2) != 0) ? 2'b01 : 2'b00, 5'($urandom)};
            wr_byte(c);
            n = 1 + $urandom % 4;
            if (($urandom % 2) != 0) begin
                frame(1);
                for (int k = 0; k < n; k++) rd_byte("R7 random read");
            end else begin
                for (int k = 0; k < n; k++) wr_byte(8'($urandom));
            end
            frame(0);
            if (t % 40 == 0) chk_cfg();
        end
        chk_cfg();
        finish_run();
    end
endmodule